// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle and Break Frames

This block turns words written by software into asynchronous serial frames on a single output line. Each frame is one low start bit, eight or nine data bits sent least significant bit first, and one high stop bit. Every bit lasts sixteen pulses of a shared oversampling tick that comes in from a separate rate generator. A one-word holding register sits in front of the shifter, so the next word can be written while the current one is still on the line. Frames then follow one another with no gap.

Besides data, the block sends two special frames. An idle frame holds the line high for one whole frame length. It is requested by dropping the enable low and raising it again while a frame is on the line. A break frame holds the line low for one whole frame length, stop slot included, and is then followed by at least one high bit time. It is requested by raising the break control. A short raise queues exactly one break after the frame in progress. Holding the control high repeats breaks. Two status flags, holding-register-empty and transmission-complete, each drive an interrupt output through their own enable.

Top module: `sertx_framer`

## Requirements
- R1: After reset the line is high and released (`txd`=1, `txd_oe`=0), `empty_flag`=1 and `done_flag`=1.
- R2: With `nine_bit_mode`=0 a written byte is sent as 10 bits: start 0, data bits LSB first, stop 1. Each bit lasts 16 `baud_tick` pulses. The line only rises at a tick.
- R3: With `nine_bit_mode`=1 the frame is 11 bits and the bit after the eight data bits equals `ninth_bit`.
- R4: `empty_flag` clears in the cycle after a `data_wr` strobe and sets again when the held word moves into the shifter. A word written while a frame is in progress follows with no idle gap: the two start edges are 160 ticks apart in 8-bit mode.
- R5: `done_flag` clears on a `data_wr` strobe or when any frame starts. It sets when a frame ends with no data, idle frame or break pending. While it is 1 the line is high.
- R6: While `tx_en`=0 no new frame starts, a written word stays held with `empty_flag`=0, and once the line is idle `txd_oe`=0 with `txd`=1.
- R7: Taking `tx_en` low and then high while a frame is on the line queues one all-ones frame of full frame length after that frame. In 8-bit mode a following word's start edge is therefore 320 ticks after the current word's start edge.
- R8: Raising `brk_req` and lowering it during a frame queues one all-zero frame of full frame length after that frame, stop slot included. A high guard bit of 16 ticks follows, and no further break is sent.
- R9: While `brk_req` stays 1, break frames repeat, each followed by its 16-tick high guard bit.
- R10: When a frame ends, a pending break goes first, then a pending idle frame, then held data.
- R11: `empty_irq` = `empty_flag` AND `empty_irq_en`, and `done_irq` = `done_flag` AND `done_irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle oversampling pulse, 16 per bit |
| tx_en | input | 1 | Transmitter enable |
| nine_bit_mode | input | 1 | 0: 8 data bits, 1: 9 data bits |
| ninth_bit | input | 1 | Ninth data bit used in 9-bit mode |
| brk_req | input | 1 | Send-break control |
| data_wr | input | 1 | Write strobe for the holding register |
| data_in | input | 8 | Word to send |
| empty_irq_en | input | 1 | Enable for the empty interrupt |
| done_irq_en | input | 1 | Enable for the complete interrupt |
| txd | output | 1 | Serial line |
| txd_oe | output | 1 | Line drive enable (0 = released) |
| empty_flag | output | 1 | Holding register empty |
| done_flag | output | 1 | Transmission complete |
| empty_irq | output | 1 | Gated empty interrupt |
| done_irq | output | 1 | Gated complete interrupt |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse and that reset is held for some cycles before release. They also assume that `data_wr` is never raised in the cycle where the held word is moved into the shifter, because a write wins that race. The bench produces the tick every fourth clock from a free-running divider. It issues each write once the previous word has been taken or while the line is idle. It changes `tx_en` and `brk_req` only on falling clock edges and well inside the first bit of a frame.

// File: rtl/sertx_framer.sv
module sertx_framer #(
  parameter int DATA_W = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              nine_bit_mode,
  input  logic              ninth_bit,
  input  logic              brk_req,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              empty_irq_en,
  input  logic              done_irq_en,
  output logic              txd,
  output logic              txd_oe,
  output logic              empty_flag,
  output logic              done_flag,
  output logic              empty_irq,
  output logic              done_irq
);
  localparam int FW = DATA_W + 3;
  localparam int LW = $clog2(FW + 1);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] TMAX = CW'(OVERSAMPLE - 1);

  typedef enum logic [1:0] {K_DATA, K_IDLE, K_BRK, K_GUARD} kind_t;

  logic              running;
  kind_t             kind_q, nxt_kind;
  logic [FW-1:0]     fr_q, nxt_fr;
  logic [LW-1:0]     left_q, nxt_len;
  logic [CW-1:0]     tcnt_q;
  logic [DATA_W-1:0] hold_q;
  logic              hold_full, pre_pend, brk_pend, en_q, brk_q;
  logic              go, take_brk, take_pre, take_data;

  wire bit_end   = running && baud_tick && (tcnt_q == TMAX);
  wire frame_end = bit_end && (left_q == LW'(1));
  wire pick      = !running || frame_end;
  wire [LW-1:0] flen = nine_bit_mode ? LW'(FW) : LW'(FW - 1);
  wire [FW-1:0] dframe = nine_bit_mode ? {1'b1, ninth_bit, hold_q, 1'b0}
                                       : {2'b11, hold_q, 1'b0};
  wire done_set = frame_end && !go && !hold_full && !pre_pend && !brk_pend && !brk_req;

  always_comb begin
    go = 1'b0; take_brk = 1'b0; take_pre = 1'b0; take_data = 1'b0;
    nxt_kind = K_DATA; nxt_fr = '1; nxt_len = flen;
    if (pick) begin
      if (frame_end && kind_q == K_BRK) begin
        go = 1'b1; nxt_kind = K_GUARD; nxt_len = LW'(1);
      end else if (tx_en) begin
        if (brk_pend || brk_req) begin
          go = 1'b1; take_brk = 1'b1; nxt_kind = K_BRK; nxt_fr = '0;
        end else if (pre_pend) begin
          go = 1'b1; take_pre = 1'b1; nxt_kind = K_IDLE;
        end else if (hold_full) begin
          go = 1'b1; take_data = 1'b1; nxt_fr = dframe;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      kind_q  <= K_DATA;
      fr_q    <= '1;
      left_q  <= '0;
      tcnt_q  <= '0;
    end else if (go) begin
      running <= 1'b1;
      kind_q  <= nxt_kind;
      fr_q    <= nxt_fr;
      left_q  <= nxt_len;
      tcnt_q  <= '0;
    end else if (frame_end) begin
      running <= 1'b0;
      fr_q    <= '1;
      left_q  <= '0;
      tcnt_q  <= '0;
    end else if (running && baud_tick) begin
      if (tcnt_q == TMAX) begin
        tcnt_q <= '0;
        left_q <= left_q - LW'(1);
        fr_q   <= {1'b1, fr_q[FW-1:1]};
      end else begin
        tcnt_q <= tcnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0; hold_full <= 1'b0;
      empty_flag <= 1'b1; done_flag <= 1'b1;
      pre_pend <= 1'b0; brk_pend <= 1'b0;
      en_q <= 1'b0; brk_q <= 1'b0;
    end else begin
      en_q  <= tx_en;
      brk_q <= brk_req;
      pre_pend <= (pre_pend && !take_pre) || (tx_en && !en_q && running);
      brk_pend <= (brk_pend || (brk_req && !brk_q)) && !take_brk;
      if (data_wr) begin
        hold_q <= data_in; hold_full <= 1'b1; empty_flag <= 1'b0;
      end else if (take_data) begin
        hold_full <= 1'b0; empty_flag <= 1'b1;
      end
      if (data_wr || go) done_flag <= 1'b0;
      else if (done_set) done_flag <= 1'b1;
    end
  end

  assign txd       = running ? fr_q[0] : 1'b1;
  assign txd_oe    = tx_en || running;
  assign empty_irq = empty_flag && empty_irq_en;
  assign done_irq  = done_flag && done_irq_en;
endmodule

// File: rtl/sertx_framer_chk.sv
module sertx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic data_wr,
  input logic txd,
  input logic txd_oe,
  input logic empty_flag,
  input logic done_flag,
  input logic empty_irq_en,
  input logic done_irq_en,
  input logic empty_irq,
  input logic done_irq
);
  a_r6_released_high: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_oe |-> txd);
  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txd) |-> $past(baud_tick));
  a_r4_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !empty_flag);
  a_r5_write_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !done_flag);
  a_r5_done_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag |-> txd);
  a_r11_empty_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    empty_irq |-> empty_flag);
  a_r11_empty_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_irq_en |-> !empty_irq);
  a_r11_done_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> done_flag);
  a_r11_done_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !done_irq_en |-> !done_irq);
endmodule

bind sertx_framer sertx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .data_wr(data_wr),
  .txd(txd), .txd_oe(txd_oe), .empty_flag(empty_flag), .done_flag(done_flag),
  .empty_irq_en(empty_irq_en), .done_irq_en(done_irq_en),
  .empty_irq(empty_irq), .done_irq(done_irq)
);

// File: tb/tb_sertx_framer.sv
`timescale 1ns/1ps
module tb_sertx_framer;
  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
  logic tx_en = 1'b0, nine_bit_mode = 1'b0, ninth_bit = 1'b0, brk_req = 1'b0;
  logic data_wr = 1'b0, empty_irq_en = 1'b0, done_irq_en = 1'b0;
  logic [7:0] data_in = '0;
  logic txd, txd_oe, empty_flag, done_flag, empty_irq, done_irq;
  int errors = 0, checks = 0, tick_cnt = 0, tdiv = 0;
  bit finished = 1'b0;

  sertx_framer dut (.*);

  always #5 clk = ~clk;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    baud_tick = (tdiv == 0);
  end
  always @(posedge clk) if (baud_tick) tick_cnt <= tick_cnt + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!baud_tick) @(posedge clk);
    end
    #1;
  endtask

  task automatic wait_fall(output int t);
    logic prev = txd;
    int n = 0;
    t = -1;
    while (n < 6000) begin
      @(negedge clk);
      n++;
      if (prev && !txd) begin t = tick_cnt; break; end
      prev = txd;
    end
    if (t < 0) chk("R2 start edge timeout", 0, 1);
  endtask

  task automatic recv(input int nb, output logic [10:0] v, output int t);
    v = '1;
    wait_fall(t);
    wait_ticks(8);
    v[0] = txd;
    for (int i = 1; i < nb; i++) begin
      wait_ticks(16);
      v[i] = txd;
    end
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); data_wr = 1'b1; data_in = d;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 txd", txd, 1); chk("R1 txd_oe", txd_oe, 0);
    chk("R1 empty", empty_flag, 1); chk("R1 done", done_flag, 1);
  endtask

  task automatic t_byte8(input logic [7:0] d);
    logic [10:0] v; int t;
    fork
      recv(10, v, t);
      begin
        write(d);
        chk("R4 empty after write", empty_flag, 0);
        @(negedge clk);
        chk("R4 empty after load", empty_flag, 1);
        chk("R5 done cleared", done_flag, 0);
      end
    join
    chk("R2 8-bit frame", v[9:0], {1'b1, d, 1'b0});
    wait_ticks(9);
    chk("R5 done at end", done_flag, 1);
  endtask

  task automatic t_nine(input logic [7:0] d, input logic b);
    logic [10:0] v; int t;
    nine_bit_mode = 1'b1; ninth_bit = b;
    fork
      recv(11, v, t);
      write(d);
    join
    chk("R3 9-bit frame", v, {1'b1, b, d, 1'b0});
    wait_ticks(9);
    nine_bit_mode = 1'b0;
  endtask

  task automatic t_b2b;
    logic [10:0] v1, v2; int t1, t2;
    fork
      begin
        recv(10, v1, t1);
        chk("R5 done low between words", done_flag, 0);
        recv(10, v2, t2);
      end
      begin
        write(8'h3C);
        @(negedge clk);
        write(8'hC3);
      end
    join
    chk("R4 first word", v1[9:0], {1'b1, 8'h3C, 1'b0});
    chk("R4 second word", v2[9:0], {1'b1, 8'hC3, 1'b0});
    chk("R4 no gap", t2 - t1, 160);
    wait_ticks(9);
  endtask

  task automatic t_disable;
    logic [10:0] v; int t;
    @(negedge clk); tx_en = 1'b0;
    write(8'h5A);
    repeat (200) @(negedge clk);
    chk("R6 released", txd_oe, 0); chk("R6 line high", txd, 1);
    chk("R6 word held", empty_flag, 0);
    empty_irq_en = 1'b1;
    chk("R11 empty irq low while full", empty_irq, 0);
    empty_irq_en = 1'b0;
    fork
      recv(10, v, t);
      begin @(negedge clk); tx_en = 1'b1; end
    join
    chk("R6 word after enable", v[9:0], {1'b1, 8'h5A, 1'b0});
    wait_ticks(9);
  endtask

  task automatic t_pre;
    logic [10:0] v1, v2; int t1, t2;
    fork
      begin recv(10, v1, t1); recv(10, v2, t2); end
      begin
        write(8'h81);
        @(negedge clk);
        write(8'h7E);
        repeat (20) @(negedge clk);
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
        tx_en = 1'b1;
      end
    join
    chk("R7 word after idle frame", v2[9:0], {1'b1, 8'h7E, 1'b0});
    chk("R7 idle frame spacing", t2 - t1, 320);
    wait_ticks(9);
  endtask

  task automatic t_brk;
    logic [10:0] v; int t;
    fork
      recv(10, v, t);
      begin
        write(8'h0F);
        repeat (20) @(negedge clk);
        brk_req = 1'b1;
        repeat (10) @(negedge clk);
        brk_req = 1'b0;
      end
    join
    wait_ticks(88);
    chk("R8 break mid", txd, 0);
    wait_ticks(72);
    chk("R8 break stop slot", txd, 0);
    chk("R5 done low in break", done_flag, 0);
    wait_ticks(16);
    chk("R8 guard high", txd, 1);
    wait_ticks(9);
    chk("R8 done after guard", done_flag, 1);
    wait_ticks(300);
    chk("R8 single break", txd, 1);
    chk("R8 still done", done_flag, 1);
  endtask

  task automatic t_brk_held;
    int t;
    fork
      wait_fall(t);
      begin @(negedge clk); brk_req = 1'b1; end
    join
    wait_ticks(80);
    chk("R9 first break", txd, 0);
    wait_ticks(88);
    chk("R9 guard", txd, 1);
    wait_ticks(88);
    chk("R9 second break", txd, 0);
    @(negedge clk); brk_req = 1'b0;
    wait_ticks(100);
    chk("R9 stops after release", txd, 1);
    chk("R9 done", done_flag, 1);
    wait_ticks(200);
    chk("R9 no further break", txd, 1);
  endtask

  task automatic t_prio;
    logic [10:0] v; int t1, t2;
    fork
      wait_fall(t1);
      begin
        write(8'hAA);
        repeat (20) @(negedge clk);
        write(8'h55);
        brk_req = 1'b1;
        @(negedge clk); brk_req = 1'b0;
        tx_en = 1'b0;
        @(negedge clk); tx_en = 1'b1;
      end
    join
    wait_ticks(240);
    chk("R10 break first", txd, 0);
    wait_ticks(88);
    chk("R10 guard", txd, 1);
    wait_ticks(92);
    chk("R10 idle frame second", txd, 1);
    recv(10, v, t2);
    chk("R10 data last", v[9:0], {1'b1, 8'h55, 1'b0});
    chk("R10 spacing", t2 - t1, 496);
    wait_ticks(9);
  endtask

  task automatic t_irq;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      empty_irq_en = k[0]; done_irq_en = k[1];
      @(negedge clk);
      chk("R11 empty irq", empty_irq, k[0]);
      chk("R11 done irq", done_irq, k[1]);
    end
    empty_irq_en = 1'b0; done_irq_en = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    tx_en = 1'b1;
    @(negedge clk);
    chk("R6 driven when enabled", txd_oe, 1);
    t_byte8(8'hA5);
    t_byte8(8'h01);
    t_nine(8'h96, 1'b1);
    t_nine(8'hFF, 1'b0);
    t_b2b();
    t_disable();
    t_pre();
    t_brk();
    t_brk_held();
    t_prio();
    t_irq();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule